// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide NOR flash and turns one request into the bus-cycle script the flash expects. A request is made of an operation code, a 19-bit byte address, a data byte and an 8-bit sector selection. The block then drives the unlock writes, the command write or writes and the final target write. It uses its own chip-select, write-enable and output-enable strobes, and the setup, low-pulse and hold phases are counted in clock cycles.

Once the last command write has gone out, the block keeps reading the status byte at the request address. A read that returns the complement of the expected bit 7 means the embedded operation is still running. When bit 7 matches the expected value, the block raises a one-cycle done pulse. If the per-operation limit runs out before that happens, it raises a one-cycle fail pulse instead. In both cases it returns to idle.

Sector erase accepts any non-empty combination of the eight 64 KB sectors. One shared erase preamble is followed by one sector command per selected sector.

Top module: `nor_cmd_seq`

## Requirements
- R1: During and after reset the block is idle: `busy`, `op_done`, `op_fail` and `fl_dout_en` are 0, and `fl_cs_n`, `fl_we_n` and `fl_oe_n` are 1.
- R2: Operation code 0 (program) issues exactly four writes, in this order: (05555h, AAh), (02AAAh, 55h), (05555h, A0h), then (request address, request data).
- R3: Operation code 2 (whole-chip erase) issues exactly six writes, in this order: (05555h, AAh), (02AAAh, 55h), (05555h, 80h), (05555h, AAh), (02AAAh, 55h), (05555h, 10h).
- R4: Operation code 1 (sector erase) issues the first five writes of R3. It then issues one write of data 30h per set bit i of the sector mask, at address i shifted left by 16, in ascending order of i.
- R5: In every write, `fl_cs_n` stays low while `fl_we_n` is low. `fl_we_n` stays low for exactly PULSE_CYC cycles (default 5). Between pulses it stays high for at least 2 cycles. Falling edges of `fl_we_n` are at least 9 cycles apart. Address and data stay stable while `fl_cs_n` is low.
- R6: Every status read drives `fl_oe_n` low with `fl_cs_n` low and `fl_we_n` high, never drives the data bus, and uses the request address.
- R7: Polling ends when bit 7 of a status read equals the expected value. That value is bit 7 of the request data for a program and 1 for an erase. The block then pulses `op_done` and drops `busy` in the same cycle, after exactly one read more than the number of reads that returned the complement.
- R8: If no read matches, the block pulses `op_fail` at the end of the first read that completes after polling has lasted the operation's limit. The limits are PROG_TMO, SECT_TMO and CHIP_TMO cycles.
- R9: A request made while `busy` is 1 is ignored, and so is a request with operation code 3: neither starts a flash cycle.
- R10: `op_done` and `op_fail` are never high together, and each is high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_op | input | 2 | 0 program, 1 sector erase, 2 chip erase, 3 unused |
| req_addr | input | 19 | Program target and status-read address |
| req_data | input | 8 | Byte to program |
| req_sect_mask | input | 8 | One bit per sector to erase |
| busy | output | 1 | Request in progress |
| op_done | output | 1 | One-cycle pulse on successful completion |
| op_fail | output | 1 | One-cycle pulse when the limit expires |
| fl_addr | output | 19 | Flash address |
| fl_dout | output | 8 | Flash write data |
| fl_dout_en | output | 1 | Drive enable for the flash data bus |
| fl_din | input | 8 | Flash read data |
| fl_cs_n | output | 1 | Flash chip select, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |

## Verification
Some properties are checked on every cycle. Write enable must only fall inside chip select, and the read strobe must never meet a driven bus. The low pulse must have its exact width, and the address must hold while selected. The done and fail pulses must be single and exclusive, and each mask step must retire exactly one sector. Other behaviour is only visible through the bench's directed scenarios, with a flash model that stays busy for a chosen number of reads. These cover the exact order of the command bytes for each operation, ascending sector order, the expected polarity of bit 7, the number of polling reads, the choice of limit per operation, and requests that are dropped.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;
    localparam int SECT_N = 8;
    localparam int SECT_W = $clog2(SECT_N);
    localparam int STEP_W = 3;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_CMD,
        S_SECT,
        S_POLL
    } seq_st_e;

    typedef enum logic [2:0] {
        P_IDLE,
        P_SETUP,
        P_PULSE,
        P_HOLD,
        P_READ
    } phy_st_e;

    typedef struct packed {
        addr_t addr;
        data_t data;
    } bus_word_t;

    // unlock addresses and command bytes
    localparam addr_t KEY_ADDR_HI = 19'h05555;
    localparam addr_t KEY_ADDR_LO = 19'h02AAA;
    localparam data_t KEY_BYTE_1  = 8'hAA;
    localparam data_t KEY_BYTE_2  = 8'h55;
    localparam data_t CMD_WRITE   = 8'hA0;
    localparam data_t CMD_ERASE   = 8'h80;
    localparam data_t CMD_ALL     = 8'h10;
    localparam data_t CMD_SECTOR  = 8'h30;

    // index of the final scripted step per operation
    localparam step_t LAST_PROG   = 3'd3;
    localparam step_t LAST_PRE    = 3'd4;
    localparam step_t LAST_CHIP   = 3'd5;

    function automatic bus_word_t cmd_word(op_e op, step_t step, addr_t tgt, data_t dat);
        bus_word_t w;
        case (step)
            3'd0:    w = '{addr: KEY_ADDR_HI, data: KEY_BYTE_1};
            3'd1:    w = '{addr: KEY_ADDR_LO, data: KEY_BYTE_2};
            3'd2:    w = '{addr: KEY_ADDR_HI, data: (op == OP_PROG) ? CMD_WRITE : CMD_ERASE};
            3'd3:    w = (op == OP_PROG) ? '{addr: tgt, data: dat}
                                         : '{addr: KEY_ADDR_HI, data: KEY_BYTE_1};
            3'd4:    w = '{addr: KEY_ADDR_LO, data: KEY_BYTE_2};
            default: w = '{addr: KEY_ADDR_HI, data: CMD_ALL};
        endcase
        return w;
    endfunction

    function automatic addr_t sect_base(logic [SECT_W-1:0] idx);
        return {idx, {(ADDR_W-SECT_W){1'b0}}};
    endfunction

endpackage

// File: rtl/nor_bus_phy.sv
module nor_bus_phy
    import nor_seq_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 5,
    parameter int HOLD_CYC  = 2,
    parameter int READ_CYC  = 10
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      is_read,
    input  bus_word_t word,
    output logic      idle,
    output logic      done,
    output data_t     rd_data,
    output addr_t     fl_addr,
    output data_t     fl_dout,
    output logic      fl_dout_en,
    input  data_t     fl_din,
    output logic      fl_cs_n,
    output logic      fl_we_n,
    output logic      fl_oe_n
);
    localparam int M_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int M_B   = (HOLD_CYC > READ_CYC) ? HOLD_CYC : READ_CYC;
    localparam int M_ALL = (M_A > M_B) ? M_A : M_B;
    localparam int CNT_W = $clog2(M_ALL + 1);
    localparam int WL_W  = CNT_W + 1;

    phy_st_e            ph_q;
    logic [CNT_W-1:0]   cnt_q;
    bus_word_t          word_q;
    data_t              rd_q;
    logic               done_q;
    logic               last_setup, last_pulse, last_hold, last_read;

    assign last_setup = (cnt_q == CNT_W'(SETUP_CYC - 1));
    assign last_pulse = (cnt_q == CNT_W'(PULSE_CYC - 1));
    assign last_hold  = (cnt_q == CNT_W'(HOLD_CYC - 1));
    assign last_read  = (cnt_q == CNT_W'(READ_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= P_IDLE;
            cnt_q  <= '0;
            word_q <= '0;
            rd_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (ph_q)
                P_IDLE: begin
                    if (start) begin
                        word_q <= word;
                        cnt_q  <= '0;
                        ph_q   <= is_read ? P_READ : P_SETUP;
                    end
                end
                P_SETUP: begin
                    cnt_q <= last_setup ? '0 : cnt_q + 1'b1;
                    if (last_setup) ph_q <= P_PULSE;
                end
                P_PULSE: begin
                    cnt_q <= last_pulse ? '0 : cnt_q + 1'b1;
                    if (last_pulse) ph_q <= P_HOLD;
                end
                P_HOLD: begin
                    cnt_q <= last_hold ? '0 : cnt_q + 1'b1;
                    if (last_hold) begin
                        ph_q   <= P_IDLE;
                        done_q <= 1'b1;
                    end
                end
                P_READ: begin
                    cnt_q <= last_read ? '0 : cnt_q + 1'b1;
                    if (last_read) begin
                        rd_q   <= fl_din;
                        ph_q   <= P_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: ph_q <= P_IDLE;
            endcase
        end
    end

    assign idle       = (ph_q == P_IDLE);
    assign done       = done_q;
    assign rd_data    = rd_q;
    assign fl_addr    = word_q.addr;
    assign fl_dout    = word_q.data;
    assign fl_cs_n    = (ph_q == P_IDLE);
    assign fl_we_n    = (ph_q != P_PULSE);
    assign fl_oe_n    = (ph_q != P_READ);
    assign fl_dout_en = (ph_q == P_SETUP) || (ph_q == P_PULSE) || (ph_q == P_HOLD);

    // checker state: length of the current write-enable low run
    logic [WL_W-1:0] wl_run_q;
    always_ff @(posedge clk) begin
        if (rst)           wl_run_q <= '0;
        else if (!fl_we_n) wl_run_q <= wl_run_q + 1'b1;
        else               wl_run_q <= '0;
    end

    a_r5_we_in_cs: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_cs_n);

    a_r5_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (wl_run_q == WL_W'(PULSE_CYC)));

    a_r5_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!fl_cs_n && $past(!fl_cs_n)) |-> ($stable(fl_addr) && $stable(fl_dout)));

    a_r6_no_contention: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (!fl_dout_en && fl_we_n));

endmodule

// File: rtl/nor_sect_walk.sv
module nor_sect_walk
    import nor_seq_pkg::*;
#(
    parameter int N = SECT_N,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [N-1:0]  mask_in,
    input  logic          adv,
    output logic          any,
    output logic [IW-1:0] idx
);
    logic [N-1:0] mask_q;
    logic [N-1:0] lower_set;
    logic [N-1:0] first;

    assign lower_set[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < N; g++) begin : g_chain
            assign lower_set[g] = lower_set[g-1] | mask_q[g-1];
        end
    endgenerate

    assign first = mask_q & ~lower_set;
    assign any   = |mask_q;

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       mask_q <= '0;
        else if (load) mask_q <= mask_in;
        else if (adv)  mask_q <= mask_q & ~first;
    end

    a_r4_one_per_adv: assert property (@(posedge clk) disable iff (rst)
        (adv && !load) |=> ($countones(mask_q) + 1 == $past($countones(mask_q))));

endmodule

// File: rtl/nor_poll_timer.sv
module nor_poll_timer #(
    parameter int TMO_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run)     cnt_q <= '0;
        else if (cnt_q < limit) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q >= limit);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int SETUP_CYC = 1,
    parameter int PULSE_CYC = 5,
    parameter int HOLD_CYC  = 2,
    parameter int READ_CYC  = 10,
    parameter int TMO_W     = 40,
    parameter logic [TMO_W-1:0] PROG_TMO = TMO_W'(64'd30_000),
    parameter logic [TMO_W-1:0] SECT_TMO = TMO_W'(64'd1_500_000_000),
    parameter logic [TMO_W-1:0] CHIP_TMO = TMO_W'(64'd6_400_000_000)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [SECT_N-1:0] req_sect_mask,
    output logic              busy,
    output logic              op_done,
    output logic              op_fail,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [DATA_W-1:0] fl_dout,
    output logic              fl_dout_en,
    input  logic [DATA_W-1:0] fl_din,
    output logic              fl_cs_n,
    output logic              fl_we_n,
    output logic              fl_oe_n
);
    seq_st_e   st_q;
    op_e       op_q;
    addr_t     addr_q;
    data_t     data_q;
    step_t     step_q;
    logic      done_q, fail_q;

    logic      accept, last_cmd, exp_b7;
    logic      bus_start, bus_read, bus_idle, bus_done;
    bus_word_t bus_word;
    data_t     bus_rd;
    logic      w_any;
    logic [SECT_W-1:0] w_idx;
    logic [TMO_W-1:0]  tmo_limit;
    logic      tmo_exp;

    assign accept = (st_q == S_IDLE) && req_valid && (op_e'(req_op) != OP_NONE);
    assign exp_b7 = (op_q == OP_PROG) ? data_q[DATA_W-1] : 1'b1;

    always_comb begin
        case (op_q)
            OP_PROG: last_cmd = (step_q == LAST_PROG);
            OP_SECT: last_cmd = (step_q == LAST_PRE);
            default: last_cmd = (step_q == LAST_CHIP);
        endcase
    end

    always_comb begin
        case (op_q)
            OP_PROG: tmo_limit = PROG_TMO;
            OP_SECT: tmo_limit = SECT_TMO;
            default: tmo_limit = CHIP_TMO;
        endcase
    end

    always_comb begin
        bus_word  = cmd_word(op_q, step_q, addr_q, data_q);
        bus_start = 1'b0;
        bus_read  = 1'b0;
        case (st_q)
            S_CMD:  bus_start = bus_idle && !bus_done;
            S_SECT: begin
                bus_word  = '{addr: sect_base(w_idx), data: CMD_SECTOR};
                bus_start = bus_idle && !bus_done && w_any;
            end
            S_POLL: begin
                bus_word  = '{addr: addr_q, data: data_q};
                bus_read  = 1'b1;
                bus_start = bus_idle && !bus_done;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            op_q   <= OP_PROG;
            addr_q <= '0;
            data_q <= '0;
            step_q <= '0;
            done_q <= 1'b0;
            fail_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            case (st_q)
                S_IDLE: begin
                    if (accept) begin
                        op_q   <= op_e'(req_op);
                        addr_q <= req_addr;
                        data_q <= req_data;
                        step_q <= '0;
                        st_q   <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (bus_done) begin
                        if (last_cmd) st_q <= (op_q == OP_SECT) ? S_SECT : S_POLL;
                        else          step_q <= step_q + 1'b1;
                    end
                end
                S_SECT: begin
                    if (!w_any) st_q <= S_POLL;
                end
                S_POLL: begin
                    if (bus_done) begin
                        if (bus_rd[DATA_W-1] == exp_b7) begin
                            done_q <= 1'b1;
                            st_q   <= S_IDLE;
                        end else if (tmo_exp) begin
                            fail_q <= 1'b1;
                            st_q   <= S_IDLE;
                        end
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    nor_bus_phy #(
        .SETUP_CYC (SETUP_CYC),
        .PULSE_CYC (PULSE_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .READ_CYC  (READ_CYC)
    ) phy_i (
        .clk        (clk),
        .rst        (rst),
        .start      (bus_start),
        .is_read    (bus_read),
        .word       (bus_word),
        .idle       (bus_idle),
        .done       (bus_done),
        .rd_data    (bus_rd),
        .fl_addr    (fl_addr),
        .fl_dout    (fl_dout),
        .fl_dout_en (fl_dout_en),
        .fl_din     (fl_din),
        .fl_cs_n    (fl_cs_n),
        .fl_we_n    (fl_we_n),
        .fl_oe_n    (fl_oe_n)
    );

    nor_sect_walk #(.N(SECT_N)) walk_i (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .mask_in (req_sect_mask),
        .adv     ((st_q == S_SECT) && bus_done),
        .any     (w_any),
        .idx     (w_idx)
    );

    nor_poll_timer #(.TMO_W(TMO_W)) tmr_i (
        .clk     (clk),
        .rst     (rst),
        .run     (st_q == S_POLL),
        .limit   (tmo_limit),
        .expired (tmo_exp)
    );

    assign busy    = (st_q != S_IDLE);
    assign op_done = done_q;
    assign op_fail = fail_q;

    a_r10_one_outcome: assert property (@(posedge clk) disable iff (rst)
        !(op_done && op_fail));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        (op_done || op_fail) |=> !(op_done || op_fail));

    a_r7_idle_on_done: assert property (@(posedge clk) disable iff (rst)
        op_done |-> !busy);

    a_r9_op_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> (!busy || $stable(op_q)));

    a_r8_fail_from_poll: assert property (@(posedge clk) disable iff (rst)
        op_fail |-> ($past(st_q) == S_POLL));

endmodule

// File: tb/nor_cmd_seq_tb_top.sv
module nor_cmd_seq_tb_top;

    localparam int LIM_PROG = 300;
    localparam int LIM_SECT = 500;
    localparam int LIM_CHIP = 700;
    localparam int PW       = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_data = '0;
    logic [7:0]  req_sect_mask = '0;
    logic        busy, op_done, op_fail;
    logic [18:0] fl_addr;
    logic [7:0]  fl_dout;
    logic        fl_dout_en;
    logic [7:0]  fl_din;
    logic        fl_cs_n, fl_we_n, fl_oe_n;

    always #5 clk = ~clk;

    nor_cmd_seq #(
        .PROG_TMO (40'(LIM_PROG)),
        .SECT_TMO (40'(LIM_SECT)),
        .CHIP_TMO (40'(LIM_CHIP))
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_sect_mask(req_sect_mask),
        .busy(busy), .op_done(op_done), .op_fail(op_fail),
        .fl_addr(fl_addr), .fl_dout(fl_dout), .fl_dout_en(fl_dout_en), .fl_din(fl_din),
        .fl_cs_n(fl_cs_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n)
    );

    int checks_n = 0;
    int errs_n   = 0;
    int cyc      = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks_n++;
        if (!ok) begin
            errs_n++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // flash model: bit 7 reads inverted while busy reads remain
    bit mdl_b7 = 1'b1;
    int mdl_left = 0;
    bit mdl_forever = 1'b0;
    assign fl_din = (mdl_forever || mdl_left > 0) ? {~mdl_b7, 7'h2A} : {mdl_b7, 7'h15};

    // bus monitor
    logic [18:0] log_a [0:31];
    logic [7:0]  log_d [0:31];
    int log_n = 0, rd_n = 0, lo_run = 0, hi_run = 0;
    int last_fall = -1000, first_rd = -1;
    int done_seen = 0, fail_seen = 0, end_cyc = 0;
    bit have_rise = 0, prev_we = 1, prev_oe = 1, prev_done = 0, prev_fail = 0;
    logic [18:0] exp_rd_addr = '0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            chk(0, "WD", "watchdog expired", cyc, 150000);
            $display("CHECKS %0d ERRORS %0d", checks_n, errs_n);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (!fl_we_n) lo_run++;
            else          hi_run++;
            if (!prev_we && fl_we_n) begin
                chk(lo_run == PW, "R5", "we low width", lo_run, PW);
                chk(!fl_cs_n && fl_dout_en, "R5", "cs/drive at we rise", fl_cs_n, 0);
                if (log_n < 32) begin
                    log_a[log_n] = fl_addr;
                    log_d[log_n] = fl_dout;
                end
                log_n++;
                lo_run = 0;
                have_rise = 1;
            end
            if (prev_we && !fl_we_n) begin
                if (have_rise) begin
                    chk(hi_run >= 2, "R5", "we high gap", hi_run, 2);
                    chk(cyc - last_fall >= 9, "R5", "write period", cyc - last_fall, 9);
                end
                last_fall = cyc;
                hi_run = 0;
            end
            if (prev_oe && !fl_oe_n) begin
                rd_n++;
                if (first_rd < 0) first_rd = cyc;
                chk(!fl_cs_n && fl_we_n && !fl_dout_en, "R6", "read strobes",
                    {fl_cs_n, fl_we_n, fl_dout_en}, 3'b010);
                chk(fl_addr == exp_rd_addr, "R6", "read address", fl_addr, exp_rd_addr);
            end
            if (!prev_oe && fl_oe_n && mdl_left > 0) mdl_left--;
            if (op_done && op_fail) chk(0, "R10", "done with fail", 1, 0);
            if (op_done && prev_done) chk(0, "R10", "done longer than one cycle", 2, 1);
            if (op_fail && prev_fail) chk(0, "R10", "fail longer than one cycle", 2, 1);
            if (op_done) begin
                done_seen++;
                end_cyc = cyc;
                chk(!busy, "R7", "busy low with done", busy, 0);
            end
            if (op_fail) begin
                fail_seen++;
                end_cyc = cyc;
            end
            prev_we = fl_we_n;
            prev_oe = fl_oe_n;
            prev_done = op_done;
            prev_fail = op_fail;
        end
    end

    // issue one request, wait for an outcome; optional stray request at poke_at
    task automatic run_op(input logic [1:0] op, input logic [18:0] a, input logic [7:0] d,
                          input logic [7:0] m, input bit b7, input int left, input bit hang,
                          input int poke_at, output int res);
        log_n = 0; rd_n = 0; have_rise = 0; first_rd = -1;
        done_seen = 0; fail_seen = 0;
        mdl_b7 = b7; mdl_left = left; mdl_forever = hang; exp_rd_addr = a;
        @(negedge clk);
        req_valid = 1; req_op = op; req_addr = a; req_data = d; req_sect_mask = m;
        @(negedge clk);
        req_valid = 0;
        res = 0;
        for (int i = 0; i < 20000 && res == 0; i++) begin
            @(negedge clk);
            if (i == poke_at) begin
                req_valid = 1; req_op = 2'd2; req_addr = 19'h7FFFF; req_sect_mask = 8'hFF;
            end else begin
                req_valid = 0;
            end
            if (done_seen > 0) res = 1;
            else if (fail_seen > 0) res = 2;
        end
        req_valid = 0;
        mdl_forever = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_log(input string req, input int n,
                           input logic [18:0] ea [0:31], input logic [7:0] ed [0:31]);
        chk(log_n == n, req, "write count", log_n, n);
        for (int i = 0; i < n && i < log_n; i++) begin
            chk(log_a[i] == ea[i], req, $sformatf("write %0d address", i), log_a[i], ea[i]);
            chk(log_d[i] == ed[i], req, $sformatf("write %0d data", i), log_d[i], ed[i]);
        end
    endtask

    task automatic t_reset();
        chk(!busy && !op_done && !op_fail, "R1", "status in reset", {busy, op_done, op_fail}, 0);
        chk(fl_cs_n && fl_we_n && fl_oe_n && !fl_dout_en, "R1", "strobes in reset",
            {fl_cs_n, fl_we_n, fl_oe_n, fl_dout_en}, 4'b1110);
        rst = 0;
        @(negedge clk);
        chk(!busy && fl_cs_n && fl_we_n && fl_oe_n && !fl_dout_en, "R1", "idle after reset",
            {busy, fl_cs_n, fl_we_n, fl_oe_n, fl_dout_en}, 5'b01110);
    endtask

    task automatic t_program(input logic [18:0] a, input logic [7:0] d, input int left);
        logic [18:0] ea [0:31];
        logic [7:0]  ed [0:31];
        int res;
        ea[0] = 19'h05555; ed[0] = 8'hAA;
        ea[1] = 19'h02AAA; ed[1] = 8'h55;
        ea[2] = 19'h05555; ed[2] = 8'hA0;
        ea[3] = a;         ed[3] = d;
        run_op(2'd0, a, d, 8'h00, d[7], left, 0, -1, res);
        chk(res == 1, "R7", "program completes", res, 1);
        cmp_log("R2", 4, ea, ed);
        chk(rd_n == left + 1, "R7", "program poll reads", rd_n, left + 1);
    endtask

    task automatic t_chip(input int left);
        logic [18:0] ea [0:31];
        logic [7:0]  ed [0:31];
        int res;
        ea[0] = 19'h05555; ed[0] = 8'hAA;
        ea[1] = 19'h02AAA; ed[1] = 8'h55;
        ea[2] = 19'h05555; ed[2] = 8'h80;
        ea[3] = 19'h05555; ed[3] = 8'hAA;
        ea[4] = 19'h02AAA; ed[4] = 8'h55;
        ea[5] = 19'h05555; ed[5] = 8'h10;
        run_op(2'd2, 19'h00100, 8'h00, 8'h00, 1'b1, left, 0, -1, res);
        chk(res == 1, "R7", "chip erase completes", res, 1);
        cmp_log("R3", 6, ea, ed);
        chk(rd_n == left + 1, "R7", "chip erase poll reads", rd_n, left + 1);
    endtask

    task automatic t_sector(input logic [7:0] m, input logic [18:0] a, input int left);
        logic [18:0] ea [0:31];
        logic [7:0]  ed [0:31];
        int n, res;
        ea[0] = 19'h05555; ed[0] = 8'hAA;
        ea[1] = 19'h02AAA; ed[1] = 8'h55;
        ea[2] = 19'h05555; ed[2] = 8'h80;
        ea[3] = 19'h05555; ed[3] = 8'hAA;
        ea[4] = 19'h02AAA; ed[4] = 8'h55;
        n = 5;
        for (int i = 0; i < 8; i++) begin
            if (m[i]) begin
                ea[n] = {3'(i), 16'h0000};
                ed[n] = 8'h30;
                n++;
            end
        end
        run_op(2'd1, a, 8'h00, m, 1'b1, left, 0, -1, res);
        chk(res == 1, "R7", "sector erase completes", res, 1);
        cmp_log("R4", n, ea, ed);
        chk(rd_n == left + 1, "R7", "sector erase poll reads", rd_n, left + 1);
    endtask

    task automatic t_timeout(input logic [1:0] op, input int lim);
        int res, span;
        run_op(op, 19'h12345, 8'h80, 8'h11, (op == 2'd0) ? 1'b1 : 1'b1, 0, 1, -1, res);
        chk(res == 2, "R8", $sformatf("op %0d times out", op), res, 2);
        span = end_cyc - first_rd;
        chk(span >= lim - 2 && span <= lim + 16, "R8",
            $sformatf("op %0d limit span", op), span, lim);
        chk(!busy && done_seen == 0, "R8", "idle without done after fail", {busy, done_seen}, 0);
    endtask

    task automatic t_ignore_busy();
        int res;
        run_op(2'd0, 19'h00042, 8'h11, 8'h00, 1'b0, 3, 0, 20, res);
        chk(res == 1, "R9", "first program completes", res, 1);
        repeat (60) @(negedge clk);
        chk(log_n == 4 && !busy, "R9", "stray request while busy dropped", log_n, 4);
        chk(done_seen == 1, "R9", "single completion", done_seen, 1);
    endtask

    task automatic t_bad_op();
        log_n = 0; rd_n = 0;
        @(negedge clk);
        req_valid = 1; req_op = 2'd3; req_addr = 19'h01234; req_sect_mask = 8'hFF;
        @(negedge clk);
        req_valid = 0;
        repeat (40) @(negedge clk);
        chk(!busy && fl_cs_n, "R9", "op code 3 ignored", {busy, fl_cs_n}, 2'b01);
        chk(log_n == 0 && rd_n == 0, "R9", "no cycles for op code 3", log_n + rd_n, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_program(19'h41234, 8'hC3, 3);
        t_program(19'h00007, 8'h5A, 0);
        t_chip(2);
        t_sector(8'b1010_0100, 19'h21000, 2);
        t_sector(8'h01, 19'h00010, 1);
        t_sector(8'h80, 19'h70010, 0);
        t_timeout(2'd0, LIM_PROG);
        t_timeout(2'd1, LIM_SECT);
        t_timeout(2'd2, LIM_CHIP);
        t_ignore_busy();
        t_bad_op();
        $display("CHECKS %0d ERRORS %0d", checks_n, errs_n);
        $finish;
    end

endmodule